// File: doc/BRIEF.md
# Sequential Pattern Trigger

This block decides when a logic-capture engine should start recording. It watches a stream of wide samples, each qualified by a valid strobe. It compares them against a chain of up to four pattern stages. Each stage holds its own mask, compare value and configuration word. At any time only one stage is live. When that stage sees a matching sample, the chain either steps to the following stage or, if the stage carries the launch flag, emits a single-cycle trigger pulse.

Software configures the stages through a register decoder that sits outside this block. Those register contents arrive here as flat vectors. The run command pulses `arm`, which restarts the chain at stage 0. Once the trigger has fired, the unit goes quiet and stays quiet until it is armed again. The common "trigger immediately" setup is stage 0 with an all-zero mask and the launch flag set. With that setup the first valid sample after arming fires the trigger.

Top module: `seq_trigger`

## Requirements
- R1: After reset, `trig` is 0 and `stage` is 0. The unit is idle, so no sample produces a trigger until `arm` has been pulsed.
- R2: The live stage s matches a sample when `((smp_data ^ value_flat[s*W +: W]) & mask_flat[s*W +: W]) == 0`. Sample bits whose mask bit is 0 have no effect on the result.
- R3: Bit 3 of a stage's configuration word (`cfg_flat[s*CW + 3]`) is the launch flag. If the live stage has this flag set and matches a valid sample, `trig` is high for exactly one cycle, in the cycle after the clock edge that took the sample.
- R4: If the live stage does not have the launch flag and matches a valid sample, `stage` increments by one after that edge. Stage s+1 is compared only from the next valid sample on. A sample that matches only a later stage leaves `stage` unchanged.
- R5: While `smp_valid` is 0, `stage` holds its value and no trigger is produced.
- R6: After the trigger has fired, further samples have no effect. `trig` stays 0 and `stage` keeps the index of the stage that fired, until the unit is re-armed.
- R7: `arm` sets `stage` to 0 and makes the unit live. A sample presented in the same cycle as `arm` is ignored.
- R8: If stage 0 has mask 0 and the launch flag set, the trigger fires on the first valid sample after arming.
- R9: If the last stage (index N-1) matches but does not have the launch flag, `stage` stays at N-1 and no trigger is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Restart the chain at stage 0 and make it live |
| smp_valid | input | 1 | Qualifies `smp_data` this cycle |
| smp_data | input | W | Sample word |
| mask_flat | input | N*W | Per-stage masks, stage s at bits [s*W +: W] |
| value_flat | input | N*W | Per-stage compare values, stage s at bits [s*W +: W] |
| cfg_flat | input | N*CW | Per-stage configuration words, stage s at bits [s*CW +: CW]; bit 3 of each is the launch flag |
| trig | output | 1 | One-cycle trigger pulse |
| stage | output | $clog2(N) | Index of the live stage |

## Verification
The bench uses the default parameters: 32-bit samples, four stages and 32-bit configuration words. With these values a full four-stage chain can be exercised. The bench can hold the chain at the last stage when that stage has no launch flag, and it can check that the launch flag is decoded at bit 3 of a full-width word. The random masks are kept sparse so that matches happen often, and this drives advances, launches, re-arms and fired-state idling with real 32-bit data in the unmasked bits.

// File: rtl/seq_trigger.sv
module seq_trigger #(
  parameter int W   = 32,
  parameter int N   = 4,
  parameter int CW  = 32,
  parameter int FIN = 3,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            smp_valid,
  input  logic [W-1:0]    smp_data,
  input  logic [N*W-1:0]  mask_flat,
  input  logic [N*W-1:0]  value_flat,
  input  logic [N*CW-1:0] cfg_flat,
  output logic            trig,
  output logic [SW-1:0]   stage
);

  logic [N-1:0]  hit, fin;
  logic          live_q, trig_q;
  logic [SW-1:0] stage_q;
  logic          cur_hit, cur_fin, eval, at_last;

  for (genvar g = 0; g < N; g++) begin : g_stage
    assign hit[g] = ((smp_data ^ value_flat[g*W +: W]) & mask_flat[g*W +: W]) == '0;
    assign fin[g] = cfg_flat[g*CW + FIN];
  end

  assign cur_hit = hit[stage_q];
  assign cur_fin = fin[stage_q];
  assign at_last = (stage_q == SW'(N-1));
  assign eval    = live_q & smp_valid & ~arm & cur_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      stage_q <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= eval & cur_fin;
      if (arm) begin
        live_q  <= 1'b1;
        stage_q <= '0;
      end else if (eval) begin
        if (cur_fin)       live_q  <= 1'b0;
        else if (!at_last) stage_q <= stage_q + 1'b1;
      end
    end
  end

  assign trig  = trig_q;
  assign stage = stage_q;

  // R3
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  // R5
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !arm) |=> (!trig && stage == $past(stage)));

  // R7
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (stage == '0 && !trig));

  // R4
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (stage == $past(stage) || stage == SW'($past(stage) + 1'b1)));

  // R6
  fire_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> stage == $past(stage));

endmodule

// File: tb/seq_trigger_test.sv
module seq_trigger_test;
  localparam int W = 32, N = 4, CW = 32, SW = 2;

  logic clk = 0, rst_n = 0, arm = 0, smp_valid = 0;
  logic [W-1:0] smp_data = '0;
  logic [N*W-1:0] mask_flat = '0, value_flat = '0;
  logic [N*CW-1:0] cfg_flat = '0;
  logic trig;
  logic [SW-1:0] stage;

  int checks = 0, errors = 0;
  bit m_live = 0, m_trig = 0;
  int m_stage = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seq_trigger #(.W(W), .N(N), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid), .smp_data(smp_data),
    .mask_flat(mask_flat), .value_flat(value_flat), .cfg_flat(cfg_flat),
    .trig(trig), .stage(stage));

  function automatic bit pat_hit(int s, logic [W-1:0] d);
    return ((d ^ value_flat[s*W +: W]) & mask_flat[s*W +: W]) == '0;
  endfunction

  function automatic bit launch(int s);
    return cfg_flat[s*CW + 3];
  endfunction

  task automatic check(string req);
    checks++;
    if (trig !== m_trig || stage !== SW'(m_stage)) begin
      errors++;
      $display("FAIL %s: trig=%0b stage=%0d expected trig=%0b stage=%0d",
               req, trig, stage, m_trig, m_stage);
    end
  endtask

  task automatic step(bit a, bit v, logic [W-1:0] d, string req);
    @(negedge clk);
    arm = a; smp_valid = v; smp_data = d;
    if (a) begin
      m_live = 1; m_stage = 0; m_trig = 0;
    end else if (m_live && v && pat_hit(m_stage, d)) begin
      if (launch(m_stage)) begin m_trig = 1; m_live = 0; end
      else begin
        m_trig = 0;
        if (m_stage < N-1) m_stage++;
      end
    end else m_trig = 0;
    @(posedge clk); #2;
    check(req);
  endtask

  task automatic set_stage(int s, logic [W-1:0] m, logic [W-1:0] v, bit f);
    mask_flat[s*W +: W] = m;
    value_flat[s*W +: W] = v;
    cfg_flat[s*CW +: CW] = f ? 32'h0000_0008 : 32'hFFFF_FFF7;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    set_stage(0, '0, '0, 1);
    for (int s = 1; s < N; s++) set_stage(s, '0, '0, 0);
    repeat (3) @(negedge clk);
    #2 check("R1");
    rst_n = 1;
    step(0, 1, 32'h1234_5678, "R1");
    step(0, 1, 32'h0, "R1");

    step(1, 1, 32'h0, "R7");
    step(0, 0, 32'h0, "R5");
    step(0, 0, 32'hFFFF_FFFF, "R5");
    step(0, 1, 32'hDEAD_BEEF, "R8");
    step(0, 0, 32'h0, "R3");
    step(0, 1, 32'h0, "R6");
    step(0, 1, 32'h5, "R6");

    set_stage(0, 32'hFF, 32'h11, 0);
    set_stage(1, 32'hFF, 32'h22, 0);
    set_stage(2, 32'hFF00, 32'h3300, 1);
    step(1, 1, 32'h11, "R7");
    step(0, 1, 32'h22, "R4");
    step(0, 1, 32'hABCD_0011, "R2");
    step(0, 0, 32'h22, "R5");
    step(0, 1, 32'h23, "R2");
    step(0, 1, 32'h7722, "R4");
    step(0, 1, 32'h0033_00FF, "R2");
    step(0, 1, 32'h0000_3301, "R3");
    step(0, 1, 32'h0000_3301, "R6");

    set_stage(2, 32'hFF00, 32'h3300, 0);
    set_stage(3, 32'hF, 32'h9, 0);
    step(1, 0, 32'h0, "R7");
    step(0, 1, 32'h11, "R4");
    step(0, 1, 32'h22, "R4");
    step(0, 1, 32'h3300, "R4");
    step(0, 1, 32'h9, "R9");
    step(0, 1, 32'hF9, "R9");
    step(1, 1, 32'h11, "R7");

    for (int blk = 0; blk < 20; blk++) begin
      for (int s = 0; s < N; s++) begin
        logic [W-1:0] m = '0;
        for (int b = 0; b < 3; b++) m[$urandom_range(W-1)] = 1'b1;
        set_stage(s, m, $urandom, ($urandom_range(3) == 0));
      end
      for (int c = 0; c < 150; c++)
        step($urandom_range(19) == 0, $urandom_range(9) < 7, $urandom, "R2");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule